// File: doc/BRIEF.md
# Two-Channel DMA Control and Status Registers

This block is the software-facing register file of a DMA engine that has one transmit channel (channel 0) and one receive channel (channel 1). Each channel owns a control word, a status word, a current-descriptor pointer and a tail-descriptor pointer. The register port is a plain 32-bit valid/ready bus that is always ready. Writes take effect at the clock edge that accepts them. Read data is combinational in the cycle the read is presented.

The descriptor datapath sits outside the block. It reports back through three kinds of pulse per channel: a halt event, an idle event and interrupt-set events. The block returns one start pulse per channel when software moves the tail pointer of a running channel, and one level interrupt per channel. Software starts a channel by setting run, acknowledges interrupts by writing ones to the pending bits, and can soft-reset a channel through its control word.

Top module: `dma_csr_top`

## Requirements
- R1: After reset, for each channel control reads 0x0001_0000, status reads 0x0000_0001 (halted), both descriptor pointers read 0, and irq and start are low.
- R2: The channel is bit 0 of (address / 48) and the word index is (address mod 48) / 4: index 0 is control, 1 status, 2 current descriptor, 4 tail descriptor. Address 0x60 therefore aliases channel 0 control, and 0x38 is channel 1 current descriptor.
- R3: Any control write that does not trigger a soft reset stores the written word with bit 1 (tail-pointer mode) forced to 1. Writing 0 reads back as 0x2.
- R4: A control write with bit 2 set, or any control write while a soft reset is still pending, restores the reset values of control and status, including clearing the pending interrupts. The pending state ends at the next read of control, which returns bit 2 as 0. A run request made before that read leaves the channel halted.
- R5: A control write with bit 0 (run) set and no soft reset pending clears the halted (status bit 0) and idle (status bit 1) flags.
- R6: Status bits 12 to 14 are interrupt-pending flags. Writing 1 to one of them clears it and writing 0 leaves it unchanged. Status bits 0 and 1 cannot be written by software.
- R7: A channel's irq is high exactly when a pending bit and the enable bit at the same position in control (bits 12 to 14) are both 1.
- R8: A tail-pointer write stores the value and clears the idle flag. If the channel is running (run = 1 and halted = 0) before the write, start for that channel is high for exactly the next cycle. Otherwise start stays low.
- R9: A datapath halt event sets halted, an idle event sets idle, and an interrupt-set event (ev_irq bit k of the channel maps to status bit 12+k) sets the pending bit. An event wins over a software clear of the same flag in the same cycle.
- R10: Unmapped word indices (3, 5 to 11) read as 0, and writes to them change no register.
- R11: The two channels are independent: accesses and events on one channel leave the other channel's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Always 1; every request is accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| ev_halt | input | 2 | Per-channel halt event pulse |
| ev_idle | input | 2 | Per-channel idle event pulse |
| ev_irq | input | 6 | Interrupt-set pulses, three per channel (channel 0 in bits 2:0) |
| irq | output | 2 | Per-channel interrupt level |
| start | output | 2 | Per-channel one-cycle start pulse |

## Verification
The key collision is a datapath interrupt-set event arriving in the same cycle that software writes a one to clear that same pending bit. The same kind of collision occurs between an idle event and a tail-pointer write. The bench drives the event inputs and the bus write together for one cycle. It then reads status back and watches irq: the pending bit must survive and the interrupt must stay asserted. It also checks that a halt reported by the datapath suppresses the next start pulse.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int unsigned NCH       = 2;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned WIN_BYTES = 48;
    localparam int unsigned IRQ_W     = 3;
    localparam int unsigned IRQ_LSB   = 12;

    localparam int unsigned RUN_BIT  = 0;
    localparam int unsigned TAIL_BIT = 1;
    localparam int unsigned SRST_BIT = 2;

    localparam logic [DATA_W-1:0] CTRL_INIT = 32'h0001_0000;

    typedef enum logic [2:0] {
        RS_CTRL,
        RS_STAT,
        RS_CUR,
        RS_TAIL,
        RS_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [IRQ_W-1:0] pend;
        logic             idle;
        logic             halted;
    } chan_stat_t;

    localparam chan_stat_t STAT_INIT = '{pend: '0, idle: 1'b0, halted: 1'b1};

    function automatic logic [DATA_W-1:0] pack_stat(input chan_stat_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = s.halted;
        w[1] = s.idle;
        w[IRQ_LSB +: IRQ_W] = s.pend;
        return w;
    endfunction

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
    import dma_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              ch,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_BYTES);

    logic [ADDR_W-1:0] win_no;
    logic [ADDR_W-1:0] word_no;

    always_comb begin
        win_no  = addr / WIN;
        word_no = (addr % WIN) >> 2;
        ch      = ((win_no & ADDR_W'(1)) != '0);
        unique case (word_no)
            ADDR_W'(0): sel = RS_CTRL;
            ADDR_W'(1): sel = RS_STAT;
            ADDR_W'(2): sel = RS_CUR;
            ADDR_W'(4): sel = RS_TAIL;
            default:    sel = RS_NONE;
        endcase
    end
endmodule

// File: rtl/dma_csr_channel.sv
module dma_csr_channel
    import dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ev_halt,
    input  logic              ev_idle,
    input  logic [IRQ_W-1:0]  ev_irq,
    output logic              irq_o,
    output logic              start_o
);
    logic [DATA_W-1:0] ctrl_q, ctrl_d;
    logic [DATA_W-1:0] cur_q, cur_d;
    logic [DATA_W-1:0] tail_q, tail_d;
    chan_stat_t        stat_q, stat_d;
    logic              srst_q, srst_d;
    logic              start_q, start_d;
    logic              running;

    assign running = ctrl_q[RUN_BIT] && !stat_q.halted;

    always_comb begin
        ctrl_d  = ctrl_q;
        cur_d   = cur_q;
        tail_d  = tail_q;
        stat_d  = stat_q;
        srst_d  = srst_q;
        start_d = 1'b0;

        if (rd_en && sel == RS_CTRL)
            srst_d = 1'b0;

        if (wr_en) begin
            unique case (sel)
                RS_CTRL: begin
                    if (wdata[SRST_BIT] || srst_q) begin
                        ctrl_d = CTRL_INIT;
                        stat_d = STAT_INIT;
                        srst_d = 1'b1;
                    end else begin
                        ctrl_d = wdata;
                        ctrl_d[TAIL_BIT] = 1'b1;
                        if (wdata[RUN_BIT]) begin
                            stat_d.halted = 1'b0;
                            stat_d.idle   = 1'b0;
                        end
                    end
                end
                RS_STAT: stat_d.pend = stat_q.pend & ~wdata[IRQ_LSB +: IRQ_W];
                RS_CUR:  cur_d = wdata;
                RS_TAIL: begin
                    tail_d      = wdata;
                    stat_d.idle = 1'b0;
                    start_d     = running;
                end
                default: ;
            endcase
        end

        // datapath events take priority over software clears
        if (ev_halt) stat_d.halted = 1'b1;
        if (ev_idle) stat_d.idle   = 1'b1;
        stat_d.pend = stat_d.pend | ev_irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_INIT;
            stat_q  <= STAT_INIT;
            cur_q   <= '0;
            tail_q  <= '0;
            srst_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_d;
            stat_q  <= stat_d;
            cur_q   <= cur_d;
            tail_q  <= tail_d;
            srst_q  <= srst_d;
            start_q <= start_d;
        end
    end

    always_comb begin
        unique case (sel)
            RS_CTRL: rdata = ctrl_q;
            RS_STAT: rdata = pack_stat(stat_q);
            RS_CUR:  rdata = cur_q;
            RS_TAIL: rdata = tail_q;
            default: rdata = '0;
        endcase
    end

    assign irq_o   = |(stat_q.pend & ctrl_q[IRQ_LSB +: IRQ_W]);
    assign start_o = start_q;
endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
    import dma_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    output logic                 bus_ready,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [1:0]           ev_halt,
    input  logic [1:0]           ev_idle,
    input  logic [5:0]           ev_irq,
    output logic [1:0]           irq,
    output logic [1:0]           start
);
    logic        ch;
    reg_sel_e    sel;
    logic [DATA_W-1:0] rd_ch [NCH];

    assign bus_ready = 1'b1;

    dma_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .ch   (ch),
        .sel  (sel)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = bus_valid && (ch == c[0]);

        dma_csr_channel u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (hit && bus_write),
            .rd_en   (hit && !bus_write),
            .sel     (sel),
            .wdata   (bus_wdata),
            .rdata   (rd_ch[c]),
            .ev_halt (ev_halt[c]),
            .ev_idle (ev_idle[c]),
            .ev_irq  (ev_irq[c*IRQ_W +: IRQ_W]),
            .irq_o   (irq[c]),
            .start_o (start[c])
        );
    end

    assign bus_rdata = rd_ch[ch];
endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        irq,
    input logic [1:0]        start
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq == 2'b00 && start == 2'b00));

    a_r8_one_start_at_a_time: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start));

    for (genvar c = 0; c < 2; c++) begin : g_c
        logic tail_wr;
        assign tail_wr = bus_valid && bus_write &&
                         ((bus_addr % ADDR_W'(48)) == ADDR_W'(16)) &&
                         (((bus_addr / ADDR_W'(48)) % ADDR_W'(2)) == ADDR_W'(c));

        a_r8_start_follows_tail_write: assert property (@(posedge clk) disable iff (rst)
            start[c] |-> $past(tail_wr));

        a_r7_irq_drops_only_on_write: assert property (@(posedge clk) disable iff (rst)
            $fell(irq[c]) |-> $past(bus_valid && bus_write));
    end
endmodule

bind dma_csr_top dma_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .irq       (irq),
    .start     (start)
);

// File: tb/sim_dma_csr_top.sv
`timescale 1ns/1ps
module sim_dma_csr_top;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic              bus_ready;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [1:0]        ev_halt = '0;
    logic [1:0]        ev_idle = '0;
    logic [5:0]        ev_irq = '0;
    logic [1:0]        irq;
    logic [1:0]        start;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t rd_q[$];

    always #10 clk = ~clk;

    dma_csr_top #(.ADDR_W(ADDR_W)) u0 (.*);

    // monitor: compares every read against the expectation queue
    always @(negedge clk) begin
        if (bus_valid && !bus_write) begin
            rd_item_t it;
            checks++;
            if (rd_q.size() == 0) begin
                failures++;
                $display("FAIL read with no expectation: got %h", bus_rdata);
            end else begin
                it = rd_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        it.exp = e; it.tag = tag;
        rd_q.push_back(it);
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic ev(input logic [1:0] h, input logic [1:0] i, input logic [5:0] q);
        @(posedge clk); #1;
        ev_halt = h; ev_idle = i; ev_irq = q;
        @(posedge clk); #1;
        ev_halt = '0; ev_idle = '0; ev_irq = '0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk({30'd0, irq}, 32'd0, "R1 irq low");
        chk({30'd0, start}, 32'd0, "R1 start low");
        rd(8'h00, 32'h0001_0000, "R1 ctrl0");
        rd(8'h04, 32'h0000_0001, "R1 stat0");
        rd(8'h08, 32'h0, "R1 cur0");
        rd(8'h10, 32'h0, "R1 tail0");
        rd(8'h30, 32'h0001_0000, "R1 ctrl1");
        rd(8'h34, 32'h0000_0001, "R1 stat1");

        // R8: tail write while halted gives no start
        wr(8'h10, 32'h100);
        @(negedge clk);
        chk({30'd0, start}, 32'd0, "R8 no start when halted");
        rd(8'h10, 32'h100, "R8 tail stored");

        // R3: tail mode forced
        wr(8'h30, 32'h0);
        rd(8'h30, 32'h2, "R3 ctrl1 forced bit1");

        // R9/R5: idle event then run write
        ev(2'b00, 2'b01, 6'd0);
        rd(8'h04, 32'h3, "R9 idle event sets idle");
        wr(8'h00, 32'h1);
        rd(8'h04, 32'h0, "R5 run clears halted and idle");
        rd(8'h00, 32'h3, "R3 ctrl0 run with bit1");

        // R8: running channel start pulse
        ev(2'b00, 2'b01, 6'd0);
        rd(8'h04, 32'h2, "R9 idle set again");
        wr(8'h10, 32'h200);
        @(negedge clk);
        chk({30'd0, start}, 32'd1, "R8 start pulse ch0");
        @(negedge clk);
        chk({30'd0, start}, 32'd0, "R8 start single cycle");
        rd(8'h04, 32'h0, "R8 tail write clears idle");

        // R7/R6
        wr(8'h00, 32'h1001);
        ev(2'b00, 2'b00, 6'b000001);
        @(negedge clk);
        chk({30'd0, irq}, 32'd1, "R7 irq on enabled pending");
        rd(8'h04, 32'h1000, "R9 irq event sets bit12");
        wr(8'h04, 32'h0);
        rd(8'h04, 32'h1000, "R6 write zero keeps pending");
        wr(8'h04, 32'h3);
        rd(8'h04, 32'h1000, "R6 halted/idle not writable");
        wr(8'h04, 32'h1000);
        @(negedge clk);
        chk({30'd0, irq}, 32'd0, "R7 irq low after clear");
        rd(8'h04, 32'h0, "R6 w1c clears bit12");
        ev(2'b00, 2'b00, 6'b000010);
        @(negedge clk);
        chk({30'd0, irq}, 32'd0, "R7 masked pending no irq");
        rd(8'h04, 32'h2000, "R9 bit13 pending");
        wr(8'h04, 32'h2000);

        // R9: set and clear in the same cycle
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h1000;
        ev_irq = 6'b000001; ev_idle = 2'b01;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0; ev_irq = '0; ev_idle = '0;
        @(negedge clk);
        chk({30'd0, irq}, 32'd1, "R9 set beats clear irq");
        rd(8'h04, 32'h1002, "R9 set beats clear status");
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h300;
        ev_idle = 2'b01;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0; ev_idle = '0;
        rd(8'h04, 32'h1002, "R9 idle event beats tail write");
        wr(8'h04, 32'h1000);

        // R9: halt event suppresses start
        ev(2'b01, 2'b00, 6'd0);
        rd(8'h04, 32'h3, "R9 halt event sets halted");
        wr(8'h10, 32'h400);
        @(negedge clk);
        chk({30'd0, start}, 32'd0, "R8 no start after halt event");

        // R4: soft reset
        wr(8'h00, 32'h1);
        ev(2'b00, 2'b00, 6'b000001);
        wr(8'h00, 32'h1005);
        @(negedge clk);
        chk({30'd0, irq}, 32'd0, "R4 irq cleared by soft reset");
        rd(8'h04, 32'h1, "R4 status reset value");
        wr(8'h00, 32'h1);
        rd(8'h04, 32'h1, "R4 run ignored while reset pending");
        rd(8'h00, 32'h0001_0000, "R4 ctrl reads reset value, bit2 clear");
        wr(8'h00, 32'h1);
        rd(8'h04, 32'h0, "R4 run works after ctrl read");
        rd(8'h00, 32'h3, "R4 ctrl after run");

        // R11: channel 1 untouched
        rd(8'h34, 32'h1, "R11 stat1 untouched");
        rd(8'h30, 32'h2, "R11 ctrl1 untouched");
        rd(8'h40, 32'h0, "R11 tail1 untouched");

        // R2: decode
        wr(8'h38, 32'hABC);
        rd(8'h38, 32'hABC, "R2 cur1 at 0x38");
        rd(8'h08, 32'h0, "R2 cur0 separate");
        rd(8'h60, 32'h3, "R2 0x60 aliases ctrl0");

        // R10: unmapped
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0, "R10 unmapped reads zero");
        rd(8'h00, 32'h3, "R10 ctrl0 unchanged");
        rd(8'h04, 32'h0, "R10 stat0 unchanged");
        rd(8'h08, 32'h0, "R10 cur0 unchanged");

        repeat (2) @(posedge clk);
        if (rd_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard: %0d reads unmatched", rd_q.size());
        end
        finish_run();
    end
endmodule